// File: doc/BRIEF.md
# Asynchronous PSRAM Cycle Controller

This block sits between a clocked host and a 16-bit asynchronous pseudo-static RAM of 512K words. The host presents a word address, write data, a two-bit byte mask and a read/write flag with a request. It holds these steady until the controller answers with a one-cycle ready pulse. For a read, the captured word is returned on the host read-data port at the same time as that pulse.

Every access follows a fixed sequence. The address is placed on the memory pins while chip enable is still high. Chip enable then falls together with either output enable (read) or write enable (write), and the low phase lasts for a cycle count derived from the speed-grade parameter and the clock period. A write is always ended by write enable rising while chip enable stays low for one more cycle, and the write data stays driven through that cycle. After an access, chip enable is held high for a recovery time before the next access. After a read, this recovery is long enough for the memory to stop driving the shared data lines before the controller drives them.

Only the byte lanes selected in the mask are enabled on the memory. A request with an empty mask never touches the memory and is answered at once.

Top module: `psram_cyc_ctrl`

## Requirements
- R1: While reset is held, chip enable, output enable, write enable and both byte enables are high (inactive), the data output enable is low and ready is low.
- R2: A read drives chip enable and output enable low with write enable high for exactly ACC clock cycles. The data bus is sampled on the last of those cycles and appears on host_rdata when ready is high. Output enable and write enable are never low together.
- R3: The memory address is set while chip enable is high at least one cycle before chip enable falls, and it stays unchanged for as long as chip enable is low.
- R4: A write holds chip enable and write enable low for ACC cycles. Write enable then rises while chip enable stays low for one more cycle, and the data bus stays driven with unchanged data across that rising edge.
- R5: Mask bit 0 selects the lower lane (data bits 7:0, mem_be_n[0]) and mask bit 1 selects the upper lane (bits 15:8, mem_be_n[1]). A write changes only the selected lanes. A read returns the selected lanes and zero in unselected lanes. While chip enable is low, at least one byte enable is low.
- R6: A request with mask 2'b00 leaves chip enable high throughout and raises ready in the cycle right after the request is accepted. The memory contents are unchanged.
- R7: Chip enable stays high for at least one cycle between accesses. The controller never drives the data bus while output enable is low. After output enable rises, it waits at least the bus-float count (25 ns rounded up to whole cycles) before driving the data bus.
- R8: Ready is high for exactly one cycle per request.
- R9: ACC is the access time (55 ns for grade 0, 70 ns for grade 1) divided by the clock period and rounded up, with a minimum of one. From the accepting clock edge, ready is seen after ACC+2 edges for a read and ACC+3 edges for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Request, held with its operands until ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_bmask | input | 2 | Byte lane mask, bit 0 lower lane, bit 1 upper lane |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte enables, bit 0 lower, bit 1 upper, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The assertions check the pin-level rules on every cycle. These are: output and write enable are exclusive, the address holds while chip enable is low, data holds across the rising write enable, a byte lane is enabled during each access, chip enable has a high gap, the bus float is observed before driving, there is no drive during output enable, and ready is a single pulse. The bench scenarios can show things that only a memory model reveals. These are: lanes actually written or preserved, the sampled read word, the exact access and latency cycle counts, and the empty-mask request leaving the memory untouched. The model returns garbage until the access time has elapsed, so an early sample shows up as wrong data.

// File: rtl/psram_cyc_pkg.sv
package psram_cyc_pkg;

   localparam int unsigned GRADE_FAST = 0;
   localparam int unsigned GRADE_SLOW = 1;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_ACCESS = 3'd2,
      ST_HOLD   = 3'd3,
      ST_REC    = 3'd4
   } cyc_state_e;

   // Whole clock cycles covering a time, never less than one.
   function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                input int unsigned per_ns);
      int unsigned c;
      c = (t_ns + per_ns - 1) / per_ns;
      return (c == 0) ? 1 : c;
   endfunction

   // Access (cycle) time of a grade.
   function automatic int unsigned access_ns(input int unsigned grade);
      return (grade == GRADE_FAST) ? 55 : 70;
   endfunction

   // Time for the memory to release the data lines after deselect.
   function automatic int unsigned float_ns(input int unsigned grade);
      return (grade == GRADE_FAST) ? 25 : 25;
   endfunction

endpackage

// File: rtl/psram_cyc_timer.sv
module psram_cyc_timer #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/psram_cyc_fsm.sv
module psram_cyc_fsm
   import psram_cyc_pkg::*;
#(
   parameter int unsigned CNT_W      = 2,
   parameter int unsigned ACC_CYC    = 3,
   parameter int unsigned REC_RD_CYC = 2,
   parameter int unsigned REC_WR_CYC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             mask_zero,
   input  logic             op_we,
   input  logic             expired,
   output cyc_state_e       state,
   output logic             accept,
   output logic             capture,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             ready
);

   localparam logic [CNT_W-1:0] ACC_LD    = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] REC_RD_LD = CNT_W'(REC_RD_CYC - 1);
   localparam logic [CNT_W-1:0] REC_WR_LD = CNT_W'(REC_WR_CYC - 1);

   cyc_state_e st_q, st_d;
   logic       rdy_set;

   always_comb begin
      st_d     = st_q;
      accept   = 1'b0;
      capture  = 1'b0;
      load     = 1'b0;
      load_val = '0;
      rdy_set  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (req) begin
               accept = 1'b1;
               if (mask_zero) begin
                  st_d    = ST_REC;
                  load    = 1'b1;
                  rdy_set = 1'b1;
               end else begin
                  st_d = ST_SETUP;
               end
            end
         end
         ST_SETUP: begin
            st_d     = ST_ACCESS;
            load     = 1'b1;
            load_val = ACC_LD;
         end
         ST_ACCESS: begin
            if (expired) begin
               if (op_we) begin
                  st_d = ST_HOLD;
               end else begin
                  capture  = 1'b1;
                  rdy_set  = 1'b1;
                  st_d     = ST_REC;
                  load     = 1'b1;
                  load_val = REC_RD_LD;
               end
            end
         end
         ST_HOLD: begin
            rdy_set  = 1'b1;
            st_d     = ST_REC;
            load     = 1'b1;
            load_val = REC_WR_LD;
         end
         ST_REC: begin
            if (expired)
               st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         ready <= 1'b0;
      end else begin
         st_q  <= st_d;
         ready <= rdy_set;
      end
   end

   assign state = st_q;

endmodule

// File: rtl/psram_cyc_dpath.sv
module psram_cyc_dpath
   import psram_cyc_pkg::*;
#(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned LANES  = 2,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  cyc_state_e        state,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [LANES-1:0]  host_bmask,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              op_we,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q;
   logic              we_q;
   logic              active;

   // Operands are latched only at acceptance, while chip enable is high.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
         we_q    <= 1'b0;
      end else if (accept) begin
         addr_q  <= host_addr;
         wdata_q <= host_wdata;
         mask_q  <= host_bmask;
         we_q    <= host_we;
      end
   end

   assign active     = (state == ST_ACCESS) || (state == ST_HOLD);
   assign op_we      = we_q;
   assign mem_addr   = addr_q;
   assign mem_ce_n   = !active;
   assign mem_oe_n   = !((state == ST_ACCESS) && !we_q);
   assign mem_we_n   = !((state == ST_ACCESS) && we_q);
   assign mem_be_n   = active ? ~mask_q : '1;
   assign mem_dq_out = wdata_q;
   assign mem_dq_oe  = we_q && ((state == ST_SETUP) || active);

   // One capture register per byte lane; unselected lanes read as zero.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_q <= '0;
         else if (capture)
            lane_q <= mask_q[l] ? mem_dq_in[l*8 +: 8] : 8'h00;
      end
      assign host_rdata[l*8 +: 8] = lane_q;
   end

endmodule

// File: rtl/psram_cyc_ctrl.sv
module psram_cyc_ctrl
   import psram_cyc_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned SPEED_GRADE   = GRADE_FAST,
   parameter int unsigned ADDR_W        = 19,
   parameter int unsigned LANES         = 2,
   parameter int unsigned DATA_W        = 8 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [LANES-1:0]  host_bmask,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int unsigned ACC_CYC    = ns_to_cycles(access_ns(SPEED_GRADE), CLK_PERIOD_NS);
   localparam int unsigned HZ_CYC     = ns_to_cycles(float_ns(SPEED_GRADE), CLK_PERIOD_NS);
   localparam int unsigned REC_WR_CYC = 1;
   localparam int unsigned MAX_CNT    = (ACC_CYC > HZ_CYC) ? ACC_CYC : HZ_CYC;
   localparam int unsigned CNT_W      = $clog2(MAX_CNT + 1);

   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("CLK_PERIOD_NS must be non-zero");
   end
   if (SPEED_GRADE > GRADE_SLOW) begin : g_bad_grade
      $error("SPEED_GRADE must be 0 or 1");
   end
   if (LANES < 1 || DATA_W != 8 * LANES) begin : g_bad_width
      $error("DATA_W must equal 8 * LANES");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   // Recovery after a read covers the bus float; at least one idle cycle.
   localparam int unsigned REC_RD_CYC = (HZ_CYC > 1) ? HZ_CYC : 1;

   cyc_state_e       state;
   logic             accept, capture, load, expired, op_we;
   logic [CNT_W-1:0] load_val;

   psram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   psram_cyc_fsm #(
      .CNT_W      (CNT_W),
      .ACC_CYC    (ACC_CYC),
      .REC_RD_CYC (REC_RD_CYC),
      .REC_WR_CYC (REC_WR_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (host_req),
      .mask_zero (host_bmask == '0),
      .op_we     (op_we),
      .expired   (expired),
      .state     (state),
      .accept    (accept),
      .capture   (capture),
      .load      (load),
      .load_val  (load_val),
      .ready     (host_ready)
   );

   psram_cyc_dpath #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .DATA_W (DATA_W)
   ) u_dpath (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .capture    (capture),
      .state      (state),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_bmask (host_bmask),
      .mem_dq_in  (mem_dq_in),
      .op_we      (op_we),
      .host_rdata (host_rdata),
      .mem_addr   (mem_addr),
      .mem_ce_n   (mem_ce_n),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_be_n   (mem_be_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe)
   );

endmodule

// File: rtl/psram_cyc_chk.sv
module psram_cyc_chk
   import psram_cyc_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned SPEED_GRADE   = GRADE_FAST,
   parameter int unsigned ADDR_W        = 19,
   parameter int unsigned LANES         = 2,
   parameter int unsigned DATA_W        = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [LANES-1:0]  mem_be_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   localparam int unsigned HZ_CYC = ns_to_cycles(float_ns(SPEED_GRADE), CLK_PERIOD_NS);

   logic       rst_seen = 1'b0;
   logic [7:0] hz_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rst_seen <= 1'b1;
   end

   // Cycles elapsed since output enable was last low, saturating.
   always_ff @(posedge clk) begin
      if (!rst_n)
         hz_cnt <= 8'hFF;
      else if (!mem_oe_n)
         hz_cnt <= 8'h00;
      else if (hz_cnt != 8'hFF)
         hz_cnt <= hz_cnt + 8'h01;
   end

   always @(negedge clk) begin
      if (rst_seen && !rst_n) begin
         assert_reset_idle_R1: assert (mem_ce_n && mem_oe_n && mem_we_n &&
                                       (mem_be_n == '1) && !mem_dq_oe && !host_ready)
            else $error("memory pins not idle during reset");
      end
   end

   assert_oe_we_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> $stable(mem_addr));

   assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_dq_out)));

   assert_lane_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> (mem_be_n != '1));

   assert_ce_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |=> mem_ce_n);

   assert_no_contend_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n));

   assert_bus_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (32'(hz_cnt) >= HZ_CYC));

   assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |=> !host_ready);

endmodule

bind psram_cyc_ctrl psram_cyc_chk #(
   .CLK_PERIOD_NS (CLK_PERIOD_NS),
   .SPEED_GRADE   (SPEED_GRADE),
   .ADDR_W        (ADDR_W),
   .LANES         (LANES),
   .DATA_W        (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_ready (host_ready),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_be_n   (mem_be_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/psram_cyc_ctrl_tb.sv
module psram_cyc_ctrl_tb_top;

   localparam int PER   = 20;
   localparam int ACC_B = (55 + PER - 1) / PER;
   localparam int HZ_B  = (25 + PER - 1) / PER;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [18:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [1:0]  host_bmask = '0;
   logic        host_ready;
   logic [15:0] host_rdata;
   logic [18:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]  mem_be_n;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in;

   always #10 clk = ~clk;

   psram_cyc_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_bmask(host_bmask),
      .host_ready(host_ready), .host_rdata(host_rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
      .mem_dq_oe(mem_dq_oe)
   );

   // ---------------- memory model ----------------
   logic [15:0] mdl [0:255];
   logic [15:0] shadow [0:255];
   int          ce_run_m = 0;
   logic        model_drive;
   logic [7:0]  idx;

   assign idx         = mem_addr[7:0];
   assign model_drive = !mem_ce_n && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11);

   always @(posedge clk) begin
      if (mem_ce_n) ce_run_m <= 0;
      else          ce_run_m <= ce_run_m + 1;
   end

   always_comb begin
      if (!model_drive)
         mem_dq_in = 16'hzzzz;
      else if (ce_run_m < ACC_B - 1)
         mem_dq_in = 16'hDEAD;
      else
         mem_dq_in = {mem_be_n[1] ? 8'hzz : mdl[idx][15:8],
                      mem_be_n[0] ? 8'hzz : mdl[idx][7:0]};
   end

   always @(posedge mem_we_n) begin
      if (mem_ce_n === 1'b0) begin
         for (int l = 0; l < 2; l++)
            if (!mem_be_n[l])
               mdl[idx][l*8 +: 8] = mem_dq_oe ? mem_dq_out[l*8 +: 8] : 8'hxx;
      end
   end

   // ---------------- pin monitor ----------------
   int          ce_low, we_low, oe_low, addr_err, contend, float_err;
   int          ce_hi_run = 1000, min_gap = 1000, oe_hi_run = 1000;
   logic        oe_prev = 1'b0;
   logic [18:0] exp_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_ce_n) begin
            ce_low++;
            if (mem_addr !== exp_addr) addr_err++;
            if (ce_hi_run > 0 && ce_hi_run < min_gap) min_gap = ce_hi_run;
            ce_hi_run = 0;
         end else ce_hi_run++;
         if (!mem_we_n) we_low++;
         if (mem_dq_oe && model_drive) contend++;
         if (mem_dq_oe && !oe_prev && oe_hi_run < HZ_B) float_err++;
         if (!mem_oe_n) begin oe_low++; oe_hi_run = 0; end
         else oe_hi_run++;
         oe_prev = mem_dq_oe;
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic run_op(input bit we, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] m, input bit settle,
                         output int lat, output logic [15:0] rd);
      if (settle) repeat (4) @(negedge clk);
      else        @(negedge clk);
      ce_low = 0; we_low = 0; oe_low = 0;
      exp_addr = a;
      host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_bmask = m;
      lat = 0;
      do begin
         @(posedge clk); lat++;
         @(negedge clk);
      end while (!host_ready && lat < 60);
      rd = host_rdata;
      host_req = 1'b0;
      if (we) begin
         for (int l = 0; l < 2; l++)
            if (m[l]) shadow[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
      end
   endtask

   task automatic t_reset;
      chk(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11, "R1", "enables idle in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 5'h1F);
      chk(!mem_dq_oe && !host_ready, "R1", "drive/ready low in reset",
          {mem_dq_oe, host_ready}, 0);
   endtask

   task automatic t_full_word;
      int lat; logic [15:0] rd;
      run_op(1'b1, 19'h00012, 16'hA5C3, 2'b11, 1'b1, lat, rd);
      chk(lat == ACC_B + 3, "R9", "write latency", lat, ACC_B + 3);
      chk(ce_low == ACC_B + 1, "R4", "write chip-enable cycles", ce_low, ACC_B + 1);
      chk(we_low == ACC_B, "R4", "write-enable low cycles", we_low, ACC_B);
      chk(mdl[8'h12] === 16'hA5C3, "R4", "word stored", mdl[8'h12], 16'hA5C3);
      run_op(1'b0, 19'h00012, 16'h0000, 2'b11, 1'b1, lat, rd);
      chk(lat == ACC_B + 2, "R9", "read latency", lat, ACC_B + 2);
      chk(oe_low == ACC_B && ce_low == ACC_B, "R2", "read enable cycles", oe_low, ACC_B);
      chk(rd === 16'hA5C3, "R2", "read word", rd, 16'hA5C3);
   endtask

   task automatic t_lanes;
      int lat; logic [15:0] rd;
      run_op(1'b1, 19'h00034, 16'h1234, 2'b01, 1'b1, lat, rd);
      chk(mdl[8'h34] === shadow[8'h34], "R5", "lower-lane write", mdl[8'h34], shadow[8'h34]);
      run_op(1'b0, 19'h00034, 16'h0000, 2'b11, 1'b1, lat, rd);
      chk(rd === shadow[8'h34], "R5", "read after lane write", rd, shadow[8'h34]);
      run_op(1'b0, 19'h00034, 16'h0000, 2'b10, 1'b1, lat, rd);
      chk(rd === {shadow[8'h34][15:8], 8'h00}, "R5", "upper-lane read",
          rd, {shadow[8'h34][15:8], 8'h00});
   endtask

   task automatic t_empty_mask;
      int lat; logic [15:0] rd;
      run_op(1'b1, 19'h00012, 16'hFFFF, 2'b00, 1'b1, lat, rd);
      chk(lat == 1, "R6", "empty-mask latency", lat, 1);
      chk(ce_low == 0, "R6", "empty-mask chip enable", ce_low, 0);
      run_op(1'b0, 19'h00012, 16'h0000, 2'b11, 1'b1, lat, rd);
      chk(rd === 16'hA5C3, "R6", "memory unchanged by empty mask", rd, 16'hA5C3);
   endtask

   task automatic t_top_addr;
      int lat; logic [15:0] rd;
      run_op(1'b1, 19'h7FFFF, 16'h6E91, 2'b11, 1'b1, lat, rd);
      run_op(1'b0, 19'h7FFFF, 16'h0000, 2'b11, 1'b1, lat, rd);
      chk(rd === 16'h6E91, "R3", "top address round trip", rd, 16'h6E91);
      chk(addr_err == 0, "R3", "address during chip enable", addr_err, 0);
   endtask

   task automatic t_back_to_back;
      int lat; logic [15:0] rd;
      run_op(1'b0, 19'h00012, 16'h0000, 2'b11, 1'b1, lat, rd);
      run_op(1'b1, 19'h00050, 16'hC0DE, 2'b11, 1'b0, lat, rd);
      run_op(1'b0, 19'h00050, 16'h0000, 2'b11, 1'b0, lat, rd);
      chk(rd === 16'hC0DE, "R7", "back-to-back data", rd, 16'hC0DE);
      chk(contend == 0, "R7", "bus contention events", contend, 0);
      chk(float_err == 0, "R7", "drive before bus float", float_err, 0);
      chk(min_gap >= 1 && min_gap < 1000, "R7", "chip-enable gap", min_gap, 1);
   endtask

   task automatic t_ready_pulse;
      int lat; logic [15:0] rd;
      run_op(1'b0, 19'h00034, 16'h0000, 2'b01, 1'b1, lat, rd);
      @(negedge clk);
      chk(!host_ready, "R8", "ready single cycle", host_ready, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mdl[i]    = 16'(i * 16'h0101) ^ 16'h5A3C;
         shadow[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_full_word();
      t_lanes();
      t_empty_mask();
      t_top_addr();
      t_back_to_back();
      t_ready_pulse();
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule